// File: doc/BRIEF.md
# Serial Clock-Count Write Guard

This block sits beside the command front end of a serial-clocked memory slave. It stops stray clock edges from turning into a programming cycle. Glitches on the serial clock line can slip the command by one bit and write data to the wrong place. The guard counts the clock edges the slave really saw during a transfer. When chip select falls at the end of a programming-class command, it permits the self-timed cycle only if that count equals the exact frame length the command and the current array width require.

All inputs are single-cycle strobes or levels that are already synchronised to the system clock. One strobe marks a rising serial clock edge, and one each marks the rise and the fall of chip select. Another strobe marks the cycle in which the front end found the start bit. A 3-bit class code and a width flag are sampled when chip select falls. For gated commands the guard answers with a one-cycle `exec_allow` or `exec_reject` pulse in the cycle after the fall. Commands that are not gated produce neither pulse.

A three-state machine controls the block. IDLE goes to ARMED on a chip-select rise. ARMED goes to COUNT when the start strobe arrives, back to IDLE on a chip-select fall (silent), and stays in ARMED on a repeated rise. COUNT goes to IDLE on a chip-select fall, issuing the verdict, and back to ARMED on a chip-select rise, which clears the count.

Top module: `clkcount_write_guard`

## Requirements
- R1: After reset both `exec_allow` and `exec_reject` are low, and they stay low until a transfer ends.
- R2: With `org_wide`=0, a WRITE (class 1) ending with exactly 20 counted edges gives `exec_allow` high for one cycle, the cycle after the `cs_fall` strobe.
- R3: With `org_wide`=1, a WRITE ending with exactly 27 counted edges gives `exec_allow` in the same way.
- R4: ERASE (class 2) and ERASE_ALL (class 3) are allowed only at exactly 12 counted edges when `org_wide`=0, and only at exactly 11 when `org_wide`=1.
- R5: WRITE_ALL (class 4) uses the same totals as WRITE: 20 when narrow, 27 when wide.
- R6: A gated command whose count differs from its required total gives `exec_reject` for one cycle, the cycle after `cs_fall`, and no `exec_allow`.
- R7: READ (class 0), write-enable (class 5), write-disable (class 6) and the unused code 7 never produce either pulse.
- R8: The counter saturates at 2**CNT_W-1 and does not wrap. A WRITE of 84 edges with CNT_W=6 is rejected, even though 84 mod 64 equals 20.
- R9: If chip select falls before any start strobe in that selection, neither pulse is issued.
- R10: A chip-select rise clears the count. Edges counted before a repeated rise do not add to the frame that follows it.
- R11: Each chip-select fall gives at most one pulse. `exec_allow` and `exec_reject` are never high together, and neither is high for two cycles in a row.
- R12: The start strobe counts as edge one, even when a clock-edge strobe arrives in the same cycle. Clock edges before the start strobe are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_rise | input | 1 | One-cycle strobe for a rising serial clock edge |
| cs_rise | input | 1 | One-cycle strobe for a chip-select rise |
| cs_fall | input | 1 | One-cycle strobe for a chip-select fall |
| start_det | input | 1 | One-cycle strobe when the start bit is decoded |
| instr_cls | input | 3 | Command class, sampled with `cs_fall` |
| org_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes; sampled with `cs_fall` |
| exec_allow | output | 1 | One-cycle pulse: programming cycle permitted |
| exec_reject | output | 1 | One-cycle pulse: programming cycle refused |

## Verification
The checker assumes the front end is well behaved. The `start_det` strobe comes only while chip select is high, at most once per selection. `cs_rise` and `cs_fall` never share a cycle, and the two chip-select strobes alternate. The checker also assumes `instr_cls` and `org_wide` are stable in the `cs_fall` cycle. The bench builds every frame from a single task that follows this order: rise, optional clock edges before the start, a start strobe together with its clock edge, further edges, and then a fall with the class and width already settled. Only the restart scenario issues a second rise, and it is a deliberate rise with no fall in between, which the checker's start tracking also handles.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

    typedef enum logic [2:0] {
        CLS_READ      = 3'd0,
        CLS_WRITE     = 3'd1,
        CLS_ERASE     = 3'd2,
        CLS_ERASE_ALL = 3'd3,
        CLS_WRITE_ALL = 3'd4,
        CLS_WR_EN     = 3'd5,
        CLS_WR_DIS    = 3'd6,
        CLS_SPARE     = 3'd7
    } instr_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } guard_state_e;

    // Programming-class commands carry a data field after the address.
    function automatic logic cls_has_data(input logic [2:0] c);
        return (c == CLS_WRITE) || (c == CLS_WRITE_ALL);
    endfunction

    // Commands whose launch is held back by the edge count.
    function automatic logic cls_is_gated(input logic [2:0] c);
        return (c == CLS_WRITE) || (c == CLS_WRITE_ALL) ||
               (c == CLS_ERASE) || (c == CLS_ERASE_ALL);
    endfunction

endpackage

// File: rtl/cwg_pulse_counter.sv
module cwg_pulse_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_one,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic at_top;
    assign at_top = (count == CNT_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (load_one) begin
            count <= CNT_ONE;
        end else if (inc && !at_top) begin
            count <= count + CNT_ONE;
        end
    end

endmodule

// File: rtl/cwg_len_select.sv
module cwg_len_select
    import cwg_pkg::*;
#(
    parameter int OP_W     = 2,
    parameter int ADDR_W_N = 9,
    parameter int ADDR_W_W = 8,
    parameter int DATA_W_N = 8,
    parameter int DATA_W_W = 16,
    parameter int CNT_W    = 6
) (
    input  logic [2:0]       cls,
    input  logic             org_wide,
    output logic             gated,
    output logic [CNT_W-1:0] need
);
    // start bit + opcode + address (+ data for write-type commands)
    localparam int HDR_N  = 1 + OP_W + ADDR_W_N;
    localparam int HDR_W  = 1 + OP_W + ADDR_W_W;
    localparam int FULL_N = HDR_N + DATA_W_N;
    localparam int FULL_W = HDR_W + DATA_W_W;

    localparam logic [CNT_W-1:0] NEED_HDR_N  = CNT_W'(HDR_N);
    localparam logic [CNT_W-1:0] NEED_HDR_W  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] NEED_FULL_N = CNT_W'(FULL_N);
    localparam logic [CNT_W-1:0] NEED_FULL_W = CNT_W'(FULL_W);

    logic with_data;

    always_comb begin
        gated     = cls_is_gated(cls);
        with_data = cls_has_data(cls);
        unique case ({with_data, org_wide})
            2'b00:   need = NEED_HDR_N;
            2'b01:   need = NEED_HDR_W;
            2'b10:   need = NEED_FULL_N;
            default: need = NEED_FULL_W;
        endcase
    end

endmodule

// File: rtl/clkcount_write_guard.sv
module clkcount_write_guard
    import cwg_pkg::*;
#(
    parameter int OP_W     = 2,
    parameter int ADDR_W_N = 9,
    parameter int ADDR_W_W = 8,
    parameter int DATA_W_N = 8,
    parameter int DATA_W_W = 16,
    parameter int CNT_W    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_rise,
    input  logic       cs_rise,
    input  logic       cs_fall,
    input  logic       start_det,
    input  logic [2:0] instr_cls,
    input  logic       org_wide,
    output logic       exec_allow,
    output logic       exec_reject
);
    guard_state_e     state_q, state_d;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] need_cnt;
    logic             cls_gated;
    logic             cnt_clr, cnt_load, cnt_inc;
    logic             verdict_fire;
    logic             allow_d, reject_d;

    cwg_len_select #(
        .OP_W     (OP_W),
        .ADDR_W_N (ADDR_W_N),
        .ADDR_W_W (ADDR_W_W),
        .DATA_W_N (DATA_W_N),
        .DATA_W_W (DATA_W_W),
        .CNT_W    (CNT_W)
    ) u_len (
        .cls      (instr_cls),
        .org_wide (org_wide),
        .gated    (cls_gated),
        .need     (need_cnt)
    );

    cwg_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load_one (cnt_load),
        .inc      (cnt_inc),
        .count    (edge_cnt)
    );

    // next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        cnt_load = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_rise) begin
                    state_d = ST_ARMED;
                    cnt_clr = 1'b1;
                end
            end
            ST_ARMED: begin
                if (cs_fall) begin
                    state_d = ST_IDLE;
                end else if (cs_rise) begin
                    cnt_clr = 1'b1;
                end else if (start_det) begin
                    state_d  = ST_COUNT;
                    cnt_load = 1'b1;
                end
            end
            ST_COUNT: begin
                if (cs_fall) begin
                    state_d = ST_IDLE;
                end else if (cs_rise) begin
                    state_d = ST_ARMED;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = sck_rise;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // verdict at the end of a counted frame
    always_comb begin
        verdict_fire = (state_q == ST_COUNT) && cs_fall && cls_gated;
        allow_d      = verdict_fire && (edge_cnt == need_cnt);
        reject_d     = verdict_fire && (edge_cnt != need_cnt);
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_allow  <= 1'b0;
            exec_reject <= 1'b0;
        end else begin
            exec_allow  <= allow_d;
            exec_reject <= reject_d;
        end
    end

endmodule

// File: rtl/cwg_checker.sv
module cwg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_rise,
    input logic       cs_fall,
    input logic       start_det,
    input logic [2:0] instr_cls,
    input logic       exec_allow,
    input logic       exec_reject
);
    logic start_since_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 start_since_rise <= 1'b0;
        else if (cs_fall || cs_rise) start_since_rise <= 1'b0;
        else if (start_det)          start_since_rise <= 1'b1;
    end

    logic ungated_cls;
    assign ungated_cls = (instr_cls == 3'd0) || (instr_cls >= 3'd5);

    // R11
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_allow && exec_reject));

    // R11
    single_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_allow |=> !exec_allow);

    // R11
    single_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_reject |=> !exec_reject);

    // R6
    verdict_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_allow || exec_reject) |-> $past(cs_fall));

    // R7
    ungated_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && ungated_cls) |=> !(exec_allow || exec_reject));

    // R9
    no_start_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && !start_since_rise) |=> !(exec_allow || exec_reject));

endmodule

bind clkcount_write_guard cwg_checker i_cwg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_rise     (cs_rise),
    .cs_fall     (cs_fall),
    .start_det   (start_det),
    .instr_cls   (instr_cls),
    .exec_allow  (exec_allow),
    .exec_reject (exec_reject)
);

// File: tb/test_clkcount_write_guard.sv
module test_clkcount_write_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_rise = 1'b0, cs_rise = 1'b0, cs_fall = 1'b0, start_det = 1'b0;
    logic [2:0] instr_cls = 3'd0;
    logic       org_wide = 1'b0;
    logic       exec_allow, exec_reject;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    clkcount_write_guard i_clkcount_write_guard (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_rise(cs_rise),
        .cs_fall(cs_fall), .start_det(start_det), .instr_cls(instr_cls),
        .org_wide(org_wide), .exec_allow(exec_allow), .exec_reject(exec_reject)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of strobes, driven at a falling edge, cleared at the next
    task automatic strobe(bit sr, bit cr, bit cf, bit st);
        sck_rise = sr; cs_rise = cr; cs_fall = cf; start_det = st;
        @(negedge clk);
        sck_rise = 0; cs_rise = 0; cs_fall = 0; start_det = 0;
    endtask

    int spurious;

    task automatic edges(int n);
        for (int i = 0; i < n; i++) begin
            strobe(1, 0, 0, 0);
            if (exec_allow || exec_reject) spurious++;
        end
    endtask

    // full selection: rise, pre-start edges, start, total-1 edges, fall
    task automatic frame(string req, int pre, bit with_start, int total,
                         logic [2:0] cls, bit wide, bit exp_a, bit exp_r);
        spurious = 0;
        strobe(0, 1, 0, 0);
        edges(pre);
        if (with_start) begin
            strobe(1, 0, 0, 1);
            edges(total - 1);
        end else begin
            edges(total);
        end
        instr_cls = cls; org_wide = wide;
        check(spurious == 0, req, spurious, 0);
        strobe(0, 0, 1, 0);
        check(exec_allow == exp_a, req, exec_allow, exp_a);
        check(exec_reject == exp_r, req, exec_reject, exp_r);
        @(negedge clk);
        // R11: single-cycle pulse
        check(!exec_allow && !exec_reject, "R11", exec_allow + exec_reject, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!exec_allow && !exec_reject, "R1", exec_allow + exec_reject, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!exec_allow && !exec_reject, "R1", exec_allow + exec_reject, 0);
    endtask

    task automatic t_write_narrow();
        frame("R2", 0, 1, 20, 3'd1, 0, 1, 0);
        frame("R6", 0, 1, 19, 3'd1, 0, 0, 1);
        frame("R6", 0, 1, 21, 3'd1, 0, 0, 1);
    endtask

    task automatic t_write_wide();
        frame("R3", 0, 1, 27, 3'd1, 1, 1, 0);
        frame("R6", 0, 1, 26, 3'd1, 1, 0, 1);
        frame("R6", 0, 1, 20, 3'd1, 1, 0, 1);
    endtask

    task automatic t_erase();
        frame("R4", 0, 1, 12, 3'd2, 0, 1, 0);
        frame("R4", 0, 1, 11, 3'd2, 1, 1, 0);
        frame("R4", 0, 1, 11, 3'd3, 1, 1, 0);
        frame("R4", 0, 1, 12, 3'd3, 0, 1, 0);
        frame("R4", 0, 1, 11, 3'd3, 0, 0, 1);
        frame("R4", 0, 1, 12, 3'd2, 1, 0, 1);
    endtask

    task automatic t_write_all();
        frame("R5", 0, 1, 20, 3'd4, 0, 1, 0);
        frame("R5", 0, 1, 27, 3'd4, 1, 1, 0);
        frame("R5", 0, 1, 27, 3'd4, 0, 0, 1);
    endtask

    task automatic t_ungated();
        frame("R7", 0, 1, 27, 3'd0, 1, 0, 0);
        frame("R7", 0, 1, 11, 3'd5, 1, 0, 0);
        frame("R7", 0, 1, 12, 3'd6, 0, 0, 0);
        frame("R7", 0, 1, 20, 3'd7, 0, 0, 0);
    endtask

    task automatic t_saturate();
        frame("R8", 0, 1, 84, 3'd1, 0, 0, 1);
    endtask

    task automatic t_no_start();
        frame("R9", 0, 0, 20, 3'd1, 0, 0, 0);
    endtask

    task automatic t_restart();
        spurious = 0;
        strobe(0, 1, 0, 0);
        strobe(1, 0, 0, 1);
        edges(9);
        strobe(0, 1, 0, 0);            // R10: repeated rise clears
        strobe(1, 0, 0, 1);
        edges(19);
        instr_cls = 3'd1; org_wide = 0;
        strobe(0, 0, 1, 0);
        check(exec_allow == 1 && spurious == 0, "R10", exec_allow, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_prestart();
        frame("R12", 3, 1, 20, 3'd1, 0, 1, 0);
        frame("R12", 5, 1, 11, 3'd2, 1, 1, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_narrow();
        t_write_wide();
        t_erase();
        t_write_all();
        t_ungated();
        t_saturate();
        t_no_start();
        t_restart();
        t_prestart();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule